// File: doc/BRIEF.md
# Fault Escalation and Lockup Controller

This block takes fault events raised by a processor pipeline and decides, in one clock, what happens to each one. There are four event lines: a direct hard fault, a memory-management fault, a bus fault and a usage fault. A two-bit context input says what is running: thread code, a configurable fault handler, the hard fault handler or the NMI handler. Outside the hard fault and NMI handlers, the block routes each configurable fault to its own handler. If that handler is disabled, it promotes the fault to hard fault. It then announces the chosen handler with a one-cycle dispatch strobe. Inside the hard fault or NMI handler, any fault counts as a hard fault. That fault cannot preempt the running handler, so the block locks up and holds an execution-halt line high.

Every event, whether routed, promoted or locking, ORs its cause bits into a sticky status word. Software clears these words with write-one-to-clear writes. Memory-management and bus events also latch the faulting address, but only while that word's address-valid bit is clear. Lockup ends on a debugger halt request. It also ends on an NMI, but only if the lockup was not entered from the NMI handler. Reset clears everything. Fault events are single-cycle pulses with no ready signal, because a fault cannot be held off. The block gives no back-pressure, and the producer must not expect any.

Top module: `fault_escalation_ctrl`

## Requirements
- R1: When `ctx` is 0 (thread) or 1 (configurable handler), a single enabled configurable fault raises `disp_strobe` for exactly the clock after the event. `disp_sel` shows the handler code: 1 for memory management, 2 for bus, 3 for usage. `disp_sel` is 0 whenever the strobe is low.
- R2: A configurable fault whose enable is low is dispatched as hard fault (code 4). It also sets bit 1 (escalated) of `hard_stat`.
- R3: A bus fault with `bus_stk` high is dispatched to the bus handler even when `bus_en` is low, with `disp_stk_err` high. It also sets `bus_stat` bit CAUSE_W.
- R4: Events in the same cycle are arbitrated after escalation with fixed priority: hard (a direct event or any escalated one) above memory management, above bus, above usage.
- R5: Any fault event while `ctx` is 2 (hard handler) or 3 (NMI handler) produces no dispatch. From the next clock it holds `lockup` and `halt` high.
- R6: While locked, `dbg_halt_req` always clears lockup on the next clock. `nmi_req` also clears it when the lockup began outside the NMI handler.
- R7: A lockup that began while `ctx` was 3 ignores `nmi_req`. Only a debugger halt or reset clears it.
- R8: Status bits are sticky, and new cause bits are ORed in. A write with `wr_en` clears the bits set in `wr_data` of the word chosen by `wr_sel` (0 hard, 1 memory management, 2 bus, 3 usage). A bit that is set and cleared in the same cycle ends up set.
- R9: `mm_stat` and `bus_stat` bit CAUSE_W+1 is the address-valid flag. The event address is latched into `mm_addr` or `bus_addr` only when that flag is clear, or is being cleared in the same cycle.
- R10: Fault events arriving while `lockup` is high change no status, address or dispatch output.
- R11: After reset, every status word, both addresses, `disp_strobe`, `disp_sel`, `lockup` and `halt` are zero.
- R12: A direct hard fault event dispatches code 4 and sets bit 0 (direct) of `hard_stat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctx | input | 2 | Execution context: 0 thread, 1 configurable handler, 2 hard handler, 3 NMI handler |
| mm_en | input | 1 | Memory-management handler enabled |
| bus_en | input | 1 | Bus handler enabled |
| usage_en | input | 1 | Usage handler enabled |
| hard_evt | input | 1 | Direct hard fault event |
| mm_evt | input | 1 | Memory-management fault event |
| mm_cause | input | CAUSE_W | Cause bits for the memory-management event |
| mm_addr_in | input | ADDR_W | Faulting address for the memory-management event |
| bus_evt | input | 1 | Bus fault event |
| bus_stk | input | 1 | Bus event arose while stacking for bus handler entry |
| bus_cause | input | CAUSE_W | Cause bits for the bus event |
| bus_addr_in | input | ADDR_W | Faulting address for the bus event |
| usage_evt | input | 1 | Usage fault event |
| usage_cause | input | CAUSE_W | Cause bits for the usage event |
| nmi_req | input | 1 | NMI request |
| dbg_halt_req | input | 1 | Debugger halt request |
| wr_en | input | 1 | Status clear write strobe |
| wr_sel | input | 2 | Status word selected for the write |
| wr_data | input | CAUSE_W+2 | Bits to clear, one per status bit |
| disp_strobe | output | 1 | One-cycle handler dispatch |
| disp_sel | output | 3 | Handler code: 0 none, 1 mem, 2 bus, 3 usage, 4 hard |
| disp_stk_err | output | 1 | Dispatched bus handler had a failed stacking |
| lockup | output | 1 | Lockup state |
| halt | output | 1 | Execution halt, high during lockup |
| hard_stat | output | CAUSE_W+2 | Hard status: bit 0 direct, bit 1 escalated |
| mm_stat | output | CAUSE_W+2 | Memory-management cause bits plus address-valid at top |
| mm_addr | output | ADDR_W | Latched memory-management fault address |
| bus_stat | output | CAUSE_W+2 | Bus cause bits, stacking flag, address-valid |
| bus_addr | output | ADDR_W | Latched bus fault address |
| usage_stat | output | CAUSE_W+2 | Usage cause bits |

## Verification
The assertions assume that `bus_stk` is only raised together with `bus_evt`. They also assume that the fault source does not raise events during lockup; the block drops any that arrive. They take `ctx` as the context at the moment of the event, so the lockup flavour is fixed by the context of the entry cycle. The stimulus changes inputs only on the falling edge, holds each event for one cycle and then lowers it. It sets `bus_stk` only alongside a bus event, and it issues lockup exits only while the block is locked.

// File: rtl/fault_ctrl_pkg.sv
package fault_ctrl_pkg;
  typedef enum logic [1:0] {
    CTX_THREAD = 2'd0,
    CTX_CFG    = 2'd1,
    CTX_HARD   = 2'd2,
    CTX_NMI    = 2'd3
  } exec_ctx_e;

  typedef enum logic [2:0] {
    HSEL_NONE  = 3'd0,
    HSEL_MEM   = 3'd1,
    HSEL_BUS   = 3'd2,
    HSEL_USAGE = 3'd3,
    HSEL_HARD  = 3'd4
  } hsel_e;

  localparam int NUM_STAT = 4;
  localparam logic [1:0] WSEL_HARD  = 2'd0;
  localparam logic [1:0] WSEL_MEM   = 2'd1;
  localparam logic [1:0] WSEL_BUS   = 2'd2;
  localparam logic [1:0] WSEL_USAGE = 2'd3;
endpackage

// File: rtl/fault_route.sv
module fault_route
  import fault_ctrl_pkg::*;
(
  input  exec_ctx_e ctx,
  input  logic      mm_en,
  input  logic      bus_en,
  input  logic      usage_en,
  input  logic      hard_evt,
  input  logic      mm_evt,
  input  logic      bus_evt,
  input  logic      bus_stk,
  input  logic      usage_evt,
  output logic      route_disp,
  output logic      route_lock,
  output hsel_e     route_sel,
  output logic      route_esc,
  output logic      route_stk
);
  logic any_evt, in_fixed, mm_esc, bus_esc, usage_esc, to_hard;

  always_comb begin
    any_evt   = hard_evt | mm_evt | bus_evt | usage_evt;
    in_fixed  = (ctx == CTX_HARD) || (ctx == CTX_NMI);
    mm_esc    = mm_evt & ~mm_en;
    bus_esc   = bus_evt & ~bus_en & ~bus_stk;
    usage_esc = usage_evt & ~usage_en;
    route_esc = mm_esc | bus_esc | usage_esc;
    to_hard   = hard_evt | route_esc;

    route_lock = any_evt & in_fixed;
    route_disp = any_evt & ~in_fixed;

    if (to_hard)        route_sel = HSEL_HARD;
    else if (mm_evt)    route_sel = HSEL_MEM;
    else if (bus_evt)   route_sel = HSEL_BUS;
    else if (usage_evt) route_sel = HSEL_USAGE;
    else                route_sel = HSEL_NONE;
    if (!route_disp) route_sel = HSEL_NONE;

    route_stk = route_disp && (route_sel == HSEL_BUS) && bus_stk;
  end
endmodule

// File: rtl/fault_status.sv
module fault_status
  import fault_ctrl_pkg::*;
#(
  parameter int CAUSE_W = 4,
  parameter int ADDR_W  = 32,
  localparam int STAT_W = CAUSE_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hard_evt,
  input  logic               esc_evt,
  input  logic               mm_evt,
  input  logic [CAUSE_W-1:0] mm_cause,
  input  logic [ADDR_W-1:0]  mm_addr_in,
  input  logic               bus_evt,
  input  logic               bus_stk,
  input  logic [CAUSE_W-1:0] bus_cause,
  input  logic [ADDR_W-1:0]  bus_addr_in,
  input  logic               usage_evt,
  input  logic [CAUSE_W-1:0] usage_cause,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [STAT_W-1:0]  wr_data,
  output logic [STAT_W-1:0]  hard_stat,
  output logic [STAT_W-1:0]  mm_stat,
  output logic [STAT_W-1:0]  bus_stat,
  output logic [STAT_W-1:0]  usage_stat,
  output logic [ADDR_W-1:0]  mm_addr,
  output logic [ADDR_W-1:0]  bus_addr
);
  localparam int VLD_BIT = STAT_W - 1;
  localparam int AUX_BIT = CAUSE_W;
  localparam int NUM_CAP = 2;

  logic [STAT_W-1:0] stat_q   [NUM_STAT];
  logic [STAT_W-1:0] stat_set [NUM_STAT];
  logic [STAT_W-1:0] stat_clr [NUM_STAT];

  always_comb begin
    stat_set[0] = '0;
    stat_set[0][0] = hard_evt;
    stat_set[0][1] = esc_evt;

    stat_set[1] = '0;
    stat_set[1][CAUSE_W-1:0] = mm_evt ? mm_cause : '0;
    stat_set[1][VLD_BIT] = mm_evt;

    stat_set[2] = '0;
    stat_set[2][CAUSE_W-1:0] = bus_evt ? bus_cause : '0;
    stat_set[2][AUX_BIT] = bus_evt & bus_stk;
    stat_set[2][VLD_BIT] = bus_evt;

    stat_set[3] = '0;
    stat_set[3][CAUSE_W-1:0] = usage_evt ? usage_cause : '0;
  end

  for (genvar k = 0; k < NUM_STAT; k++) begin : g_stat
    assign stat_clr[k] = (wr_en && (wr_sel == 2'(k))) ? wr_data : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[k] <= '0;
      else        stat_q[k] <= (stat_q[k] & ~stat_clr[k]) | stat_set[k];
    end

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr[k] == '0) |=> ((stat_q[k] & $past(stat_q[k])) == $past(stat_q[k])));
  end

  logic              cap_evt  [NUM_CAP];
  logic [ADDR_W-1:0] cap_in   [NUM_CAP];
  logic [ADDR_W-1:0] cap_q    [NUM_CAP];
  logic              cap_open [NUM_CAP];

  assign cap_evt[0] = mm_evt;
  assign cap_evt[1] = bus_evt;
  assign cap_in[0]  = mm_addr_in;
  assign cap_in[1]  = bus_addr_in;

  for (genvar c = 0; c < NUM_CAP; c++) begin : g_cap
    assign cap_open[c] = ~stat_q[c+1][VLD_BIT] | stat_clr[c+1][VLD_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cap_q[c] <= '0;
      else if (cap_evt[c] && cap_open[c]) cap_q[c] <= cap_in[c];
    end

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[c+1][VLD_BIT] && !stat_clr[c+1][VLD_BIT]) |=> (cap_q[c] == $past(cap_q[c])));
  end

  assign hard_stat  = stat_q[0];
  assign mm_stat    = stat_q[1];
  assign bus_stat   = stat_q[2];
  assign usage_stat = stat_q[3];
  assign mm_addr    = cap_q[0];
  assign bus_addr   = cap_q[1];
endmodule

// File: rtl/lockup_fsm.sv
module lockup_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic enter_from_nmi,
  input  logic nmi_req,
  input  logic dbg_halt_req,
  output logic lockup
);
  typedef enum logic [1:0] {LK_RUN, LK_HELD, LK_HELD_NMI} lk_state_e;
  lk_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      LK_RUN:      if (enter) st_d = enter_from_nmi ? LK_HELD_NMI : LK_HELD;
      LK_HELD:     if (dbg_halt_req || nmi_req) st_d = LK_RUN;
      LK_HELD_NMI: if (dbg_halt_req) st_d = LK_RUN;
      default:     st_d = LK_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_RUN;
    else        st_q <= st_d;
  end

  assign lockup = (st_q != LK_RUN);

  // R7
  nmi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_HELD_NMI && nmi_req && !dbg_halt_req) |=> lockup);

  // R6
  dbg_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lockup && dbg_halt_req) |=> !lockup);
endmodule

// File: rtl/fault_escalation_ctrl.sv
module fault_escalation_ctrl
  import fault_ctrl_pkg::*;
#(
  parameter int CAUSE_W = 4,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         ctx,
  input  logic               mm_en,
  input  logic               bus_en,
  input  logic               usage_en,
  input  logic               hard_evt,
  input  logic               mm_evt,
  input  logic [CAUSE_W-1:0] mm_cause,
  input  logic [ADDR_W-1:0]  mm_addr_in,
  input  logic               bus_evt,
  input  logic               bus_stk,
  input  logic [CAUSE_W-1:0] bus_cause,
  input  logic [ADDR_W-1:0]  bus_addr_in,
  input  logic               usage_evt,
  input  logic [CAUSE_W-1:0] usage_cause,
  input  logic               nmi_req,
  input  logic               dbg_halt_req,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [CAUSE_W+1:0] wr_data,
  output logic               disp_strobe,
  output logic [2:0]         disp_sel,
  output logic               disp_stk_err,
  output logic               lockup,
  output logic               halt,
  output logic [CAUSE_W+1:0] hard_stat,
  output logic [CAUSE_W+1:0] mm_stat,
  output logic [ADDR_W-1:0]  mm_addr,
  output logic [CAUSE_W+1:0] bus_stat,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [CAUSE_W+1:0] usage_stat
);
  logic g_hard, g_mm, g_bus, g_usage, g_stk;
  logic route_disp, route_lock, route_esc, route_stk;
  hsel_e route_sel;

  assign g_hard  = hard_evt  & ~lockup;
  assign g_mm    = mm_evt    & ~lockup;
  assign g_bus   = bus_evt   & ~lockup;
  assign g_usage = usage_evt & ~lockup;
  assign g_stk   = bus_stk   & g_bus;

  fault_route u_route (
    .ctx        (exec_ctx_e'(ctx)),
    .mm_en      (mm_en),
    .bus_en     (bus_en),
    .usage_en   (usage_en),
    .hard_evt   (g_hard),
    .mm_evt     (g_mm),
    .bus_evt    (g_bus),
    .bus_stk    (g_stk),
    .usage_evt  (g_usage),
    .route_disp (route_disp),
    .route_lock (route_lock),
    .route_sel  (route_sel),
    .route_esc  (route_esc),
    .route_stk  (route_stk)
  );

  fault_status #(.CAUSE_W(CAUSE_W), .ADDR_W(ADDR_W)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .hard_evt    (g_hard),
    .esc_evt     (route_esc),
    .mm_evt      (g_mm),
    .mm_cause    (mm_cause),
    .mm_addr_in  (mm_addr_in),
    .bus_evt     (g_bus),
    .bus_stk     (g_stk),
    .bus_cause   (bus_cause),
    .bus_addr_in (bus_addr_in),
    .usage_evt   (g_usage),
    .usage_cause (usage_cause),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .hard_stat   (hard_stat),
    .mm_stat     (mm_stat),
    .bus_stat    (bus_stat),
    .usage_stat  (usage_stat),
    .mm_addr     (mm_addr),
    .bus_addr    (bus_addr)
  );

  lockup_fsm u_lock (
    .clk            (clk),
    .rst_n          (rst_n),
    .enter          (route_lock),
    .enter_from_nmi (exec_ctx_e'(ctx) == CTX_NMI),
    .nmi_req        (nmi_req),
    .dbg_halt_req   (dbg_halt_req),
    .lockup         (lockup)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_strobe  <= 1'b0;
      disp_sel     <= HSEL_NONE;
      disp_stk_err <= 1'b0;
    end else begin
      disp_strobe  <= route_disp;
      disp_sel     <= route_sel;
      disp_stk_err <= route_stk;
    end
  end

  assign halt = lockup;

  // R5
  lock_nodisp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockup |-> !disp_strobe);

  // R1
  disp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_strobe == (disp_sel != HSEL_NONE));

  // R3
  stk_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_stk_err |-> (disp_strobe && disp_sel == HSEL_BUS));

  // R10
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lockup && !wr_en) |=> ($stable(mm_stat) && $stable(bus_stat) && $stable(mm_addr)));
endmodule

// File: tb/fault_escalation_ctrl_tb.sv
module fault_escalation_ctrl_tb;
  localparam int CW = 4;
  localparam int AW = 32;
  localparam int SW = CW + 2;

  logic clk = 0, rst_n = 0;
  logic [1:0] ctx = 0;
  logic mm_en = 1, bus_en = 1, usage_en = 1;
  logic hard_evt = 0, mm_evt = 0, bus_evt = 0, bus_stk = 0, usage_evt = 0;
  logic [CW-1:0] mm_cause = 0, bus_cause = 0, usage_cause = 0;
  logic [AW-1:0] mm_addr_in = 0, bus_addr_in = 0;
  logic nmi_req = 0, dbg_halt_req = 0, wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [SW-1:0] wr_data = 0;
  logic disp_strobe, disp_stk_err, lockup, halt;
  logic [2:0] disp_sel;
  logic [SW-1:0] hard_stat, mm_stat, bus_stat, usage_stat;
  logic [AW-1:0] mm_addr, bus_addr;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fault_escalation_ctrl #(.CAUSE_W(CW), .ADDR_W(AW)) u_dut (.*);

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    hard_evt = 0; mm_evt = 0; bus_evt = 0; bus_stk = 0; usage_evt = 0;
    nmi_req = 0; dbg_halt_req = 0; wr_en = 0;
    mm_cause = 0; bus_cause = 0; usage_cause = 0;
  endtask

  task automatic clear_word(logic [1:0] sel);
    wr_en = 1; wr_sel = sel; wr_data = '1;
    tick();
    quiet();
  endtask

  task automatic clear_all();
    for (int k = 0; k < 4; k++) clear_word(2'(k));
  endtask

  task automatic t_reset();
    chk("R11 strobe", disp_strobe, 0);
    chk("R11 sel", disp_sel, 0);
    chk("R11 lockup", lockup, 0);
    chk("R11 halt", halt, 0);
    chk("R11 stats", {hard_stat, mm_stat, bus_stat, usage_stat}, 0);
    chk("R11 addrs", {mm_addr, bus_addr}, 0);
  endtask

  task automatic t_route();
    mm_evt = 1; mm_cause = 4'b0010; mm_addr_in = 32'hA000_0001;
    tick();
    chk("R1 mm strobe", disp_strobe, 1);
    chk("R1 mm sel", disp_sel, 1);
    chk("R9 mm stat", mm_stat, 6'b100010);
    chk("R9 mm addr", mm_addr, 32'hA000_0001);
    quiet();
    tick();
    chk("R1 strobe one cycle", disp_strobe, 0);
    chk("R1 sel idle", disp_sel, 0);
    usage_evt = 1; usage_cause = 4'b0001; ctx = 1;
    tick();
    chk("R1 usage sel", disp_sel, 3);
    chk("R1 usage stat", usage_stat, 6'b000001);
    quiet();
    bus_evt = 1; bus_cause = 4'b0100; bus_addr_in = 32'hB000_0001;
    tick();
    chk("R1 bus sel", disp_sel, 2);
    chk("R1 bus stk flag", disp_stk_err, 0);
    chk("R9 bus stat", bus_stat, 6'b100100);
    chk("R9 bus addr", bus_addr, 32'hB000_0001);
    quiet(); ctx = 0;
  endtask

  task automatic t_sticky();
    mm_evt = 1; mm_cause = 4'b0001; mm_addr_in = 32'hA000_0002;
    tick();
    chk("R8 mm cause ored", mm_stat, 6'b100011);
    chk("R9 mm addr held", mm_addr, 32'hA000_0001);
    quiet();
    wr_en = 1; wr_sel = 2'd1; wr_data = 6'b000010;
    tick();
    chk("R8 partial clear", mm_stat, 6'b100001);
    quiet();
    clear_word(2'd1);
    chk("R8 full clear", mm_stat, 0);
    mm_evt = 1; mm_cause = 4'b1000; mm_addr_in = 32'hA000_0003;
    tick();
    chk("R9 recapture", mm_addr, 32'hA000_0003);
    quiet();
    mm_evt = 1; mm_cause = 4'b0100; mm_addr_in = 32'hA000_0004;
    wr_en = 1; wr_sel = 2'd1; wr_data = '1;
    tick();
    chk("R8 set wins", mm_stat, 6'b100100);
    chk("R9 capture while clearing", mm_addr, 32'hA000_0004);
    quiet();
    clear_word(2'd1);
  endtask

  task automatic t_escalate();
    clear_all();
    usage_en = 0; usage_evt = 1; usage_cause = 4'b1000;
    tick();
    chk("R2 esc sel", disp_sel, 4);
    chk("R2 esc bit", hard_stat, 6'b000010);
    chk("R2 usage logged", usage_stat, 6'b001000);
    quiet(); usage_en = 1;
    clear_all();
    bus_en = 0; bus_evt = 1; bus_stk = 1; bus_cause = 4'b0001; bus_addr_in = 32'hB000_0002;
    tick();
    chk("R3 stk sel", disp_sel, 2);
    chk("R3 stk flag", disp_stk_err, 1);
    chk("R3 stk stat", bus_stat, 6'b110001);
    chk("R3 no escalate", hard_stat, 0);
    quiet(); bus_en = 1;
  endtask

  task automatic t_priority();
    clear_all();
    mm_evt = 1; bus_evt = 1; usage_evt = 1;
    tick();
    chk("R4 mm over bus usage", disp_sel, 1);
    quiet();
    bus_evt = 1; usage_evt = 1;
    tick();
    chk("R4 bus over usage", disp_sel, 2);
    quiet();
    clear_all();
    hard_evt = 1; mm_evt = 1;
    tick();
    chk("R12 direct sel", disp_sel, 4);
    chk("R12 direct bit", hard_stat, 6'b000001);
    quiet();
    clear_all();
    bus_en = 0; mm_evt = 1; bus_evt = 1;
    tick();
    chk("R4 escalated over mm", disp_sel, 4);
    chk("R4 escalated bit", hard_stat, 6'b000010);
    quiet(); bus_en = 1;
  endtask

  task automatic t_lock_hard();
    clear_all();
    ctx = 2; usage_evt = 1;
    tick();
    chk("R5 no dispatch", disp_strobe, 0);
    chk("R5 lockup", lockup, 1);
    chk("R5 halt", halt, 1);
    quiet(); ctx = 0;
    mm_evt = 1; mm_cause = 4'b0001; mm_addr_in = 32'hA000_0005;
    tick();
    chk("R10 no dispatch", disp_strobe, 0);
    chk("R10 mm stat", mm_stat, 0);
    chk("R10 mm addr", mm_addr, 32'hA000_0004);
    quiet();
    nmi_req = 1;
    tick();
    chk("R6 nmi exit", lockup, 0);
    quiet();
  endtask

  task automatic t_lock_nmi();
    ctx = 3; bus_evt = 1;
    tick();
    chk("R5 nmi ctx lock", lockup, 1);
    quiet(); ctx = 0;
    nmi_req = 1;
    tick();
    chk("R7 nmi ignored", lockup, 1);
    chk("R7 halt held", halt, 1);
    quiet();
    dbg_halt_req = 1;
    tick();
    chk("R7 dbg exit", lockup, 0);
    quiet();
    ctx = 2; hard_evt = 1;
    tick();
    chk("R5 hard ctx lock", lockup, 1);
    quiet(); ctx = 0;
    dbg_halt_req = 1;
    tick();
    chk("R6 dbg exit", lockup, 0);
    chk("R6 halt low", halt, 0);
    quiet();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    tick();
    t_route();
    t_sticky();
    t_escalate();
    t_priority();
    t_lock_hard();
    t_lock_nmi();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog got=1 exp=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule